// File: doc/BRIEF.md
# Double-Buffered Serial Receiver

This block turns an asynchronous serial line into bytes. A free-running enable, pulsing at sixteen times the bit rate, paces a small state machine. The state machine waits for a falling edge on the line and checks the start bit at its midpoint. It then samples each data bit, the optional parity bit and the stop bit at the middle of its sixteen-tick slot. The character is assembled in a shifter and handed to a single read buffer. Together the two stages hold two characters. A host reads the buffer through a one-cycle read strobe.

Each character travels with its own status bits: parity error, framing error, and a lost-data flag that marks activity on the line while nothing could be stored. A ready interrupt, which can be masked, follows the buffer-full state. An active-low receive-enable output goes inactive only when both stages are occupied. A sender can use it for hardware flow control. The character length (7 or 8 bits), the parity enable and the odd/even parity choice are static configuration inputs.

Top module: `uart_rx_dbuf`

## Requirements
- R1: A reception starts only on a high-to-low transition of the synchronized line. A line held low after a character ends (a break) starts no further receptions until it has gone high and fallen again.
- R2: The start bit is checked at the 8th tick after the edge. If the line is high at that point the event is discarded as a glitch, and nothing is stored.
- R3: The first serial data bit lands in `rx_data[0]`. With `cfg_len8`=1 eight data bits are received. With `cfg_len8`=0 seven are received and `rx_data[7]` reads 0.
- R4: With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_odd`=0 selects even parity (data ones plus parity bit is even) and 1 selects odd. A mismatch sets `rx_perr` for that character.
- R5: A stop bit sampled low sets `rx_ferr` for that character.
- R6: A completed character moves into the buffer, together with its status, only while the buffer is empty. An erroneous character is still delivered, and the next character is received normally. A full buffer holds its data steady until it is read.
- R7: A read strobe while `rx_full`=1 clears `rx_full` on the next edge. A character waiting in the shifter is loaded one cycle later, which sets `rx_full` again.
- R8: `rx_irq` is 1 exactly when `rx_full`=1 and `mask_rx`=0. It is raised for every character, with or without errors.
- R9: `rx_ren_n` is 1 only while both the shifter and the buffer hold a character, and 0 otherwise.
- R10: While both stages are full no new reception starts. Any falling edge seen in that time sets `rx_ovr` on the waiting character, and that flag appears when the character reaches the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| mask_rx | input | 1 | Masks the ready interrupt |
| rd_strobe | input | 1 | Buffer read, one cycle |
| rx_data | output | 8 | Buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_perr | output | 1 | Parity error of buffered character |
| rx_ferr | output | 1 | Framing error of buffered character |
| rx_ovr | output | 1 | Line activity was lost while this character waited |
| rx_irq | output | 1 | Receive-ready interrupt |
| rx_ren_n | output | 1 | Receive enable, active low |

## Verification
The hardest condition to reach is the double-full state. It needs a second character to finish while the first is still unread. A third frame must then arrive on the line while both stages are occupied, and the waiting character must be promoted during a read. The bench withholds reads across three back-to-back frames and then issues single strobes. It observes the one-cycle gap in `rx_full`, the promoted character and its lost-data flag. Breaks and short glitches are produced by holding the line low for chosen tick counts.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int IDX_W  = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [STAGES-1:0] chain_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = rxd;
        end else begin : g_rest
            assign chain_d[g] = st_q.sync[g-1];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = chain_d;
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.sync[STAGES-1];
    assign fall = st_q.prev & ~st_q.sync[STAGES-1];

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line,
    input  logic     fall,
    input  logic     len8,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     take,
    output logic     sh_valid,
    output rx_char_t sh_char
);

    localparam int CNT_W = $clog2(OSR);
    localparam int MID   = OSR / 2 - 1;
    localparam int LAST  = OSR - 1;

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        rx_char_t         ch;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic [IDX_W-1:0] last_idx;
    logic             at_mid;
    logic             at_end;

    always_comb begin
        last_idx = len8 ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W - 2);
        at_mid   = tick && (s_q.cnt == CNT_W'(MID));
        at_end   = tick && (s_q.cnt == CNT_W'(LAST));
        s_d      = s_q;
        case (s_q.st)
            RX_IDLE: begin
                if (fall) begin
                    s_d.st  = RX_START;
                    s_d.cnt = '0;
                    s_d.idx = '0;
                    s_d.ch  = '0;
                end
            end
            RX_START: begin
                if (at_mid) begin
                    s_d.cnt = '0;
                    s_d.st  = line ? RX_IDLE : RX_DATA;
                end else if (tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (at_end) begin
                    s_d.cnt              = '0;
                    s_d.ch.data[s_q.idx] = line;
                    if (s_q.idx == last_idx) begin
                        s_d.idx = '0;
                        s_d.st  = par_en ? RX_PAR : RX_STOP;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else if (tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_PAR: begin
                if (at_end) begin
                    s_d.cnt     = '0;
                    s_d.ch.perr = line ^ (^s_q.ch.data) ^ par_odd;
                    s_d.st      = RX_STOP;
                end else if (tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (at_end) begin
                    s_d.cnt     = '0;
                    s_d.ch.ferr = ~line;
                    s_d.st      = RX_HOLD;
                end else if (tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_HOLD: begin
                if (fall) begin
                    s_d.ch.ovr = 1'b1;
                end
                if (take) begin
                    s_d.st = RX_IDLE;
                end
            end
            default: begin
                s_d.st = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign sh_valid = (s_q.st == RX_HOLD);
    assign sh_char  = s_q.ch;

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sh_valid,
    input  rx_char_t sh_char,
    input  logic     rd_strobe,
    output logic     take,
    output logic     full,
    output rx_char_t buf_char
);

    typedef struct packed {
        logic     full;
        rx_char_t ch;
    } buf_st_t;

    buf_st_t b_d, b_q;

    always_comb begin
        take = sh_valid && !b_q.full;
        b_d  = b_q;
        if (take) begin
            b_d.full = 1'b1;
            b_d.ch   = sh_char;
        end else if (rd_strobe && b_q.full) begin
            b_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign full     = b_q.full;
    assign buf_char = b_q.ch;

endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              mask_rx,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_ovr,
    output logic              rx_irq,
    output logic              rx_ren_n
);

    logic     line;
    logic     fall;
    logic     take;
    logic     sh_valid;
    rx_char_t sh_char;
    rx_char_t buf_char;
    logic     full;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .rxd  (rxd),
        .line (line),
        .fall (fall)
    );

    uart_rx_shift #(.OSR(OSR)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .line    (line),
        .fall    (fall),
        .len8    (cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .take    (take),
        .sh_valid(sh_valid),
        .sh_char (sh_char)
    );

    uart_rx_buf i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_valid (sh_valid),
        .sh_char  (sh_char),
        .rd_strobe(rd_strobe),
        .take     (take),
        .full     (full),
        .buf_char (buf_char)
    );

    assign rx_data  = buf_char.data;
    assign rx_perr  = buf_char.perr;
    assign rx_ferr  = buf_char.ferr;
    assign rx_ovr   = buf_char.ovr;
    assign rx_full  = full;
    assign rx_irq   = full & ~mask_rx;
    assign rx_ren_n = sh_valid & full;

endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic       mask_rx,
    input logic       cfg_len8,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_irq,
    input logic       rx_ren_n
);

    assert_seven_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && !cfg_len8) |-> !rx_data[7]);

    assert_buffer_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_strobe) |=> (rx_full && $stable(rx_data)));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rx_full) |=> !rx_full);

    assert_irq_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !mask_rx) |-> rx_irq);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rx |-> !rx_irq);

    assert_ren_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ren_n |-> rx_full);

    assert_no_start_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ren_n && !rd_strobe) |=> rx_ren_n);

endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strobe(rd_strobe),
    .mask_rx  (mask_rx),
    .cfg_len8 (cfg_len8),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_irq   (rx_irq),
    .rx_ren_n (rx_ren_n)
);

// File: tb/test_uart_rx_dbuf.sv
`timescale 1ns/1ps
module test_uart_rx_dbuf;

    localparam int BIT_CLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       mask_rx = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_perr, rx_ferr, rx_ovr, rx_irq, rx_ren_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) baud_tick <= 1'b0;
        else        baud_tick <= ~baud_tick;
    end

    uart_rx_dbuf i_uart_rx_dbuf (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .mask_rx(mask_rx), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_full(rx_full), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
        .rx_irq(rx_irq), .rx_ren_n(rx_ren_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip_par, input logic stop_v);
        int nb;
        logic p;
        nb = cfg_len8 ? 8 : 7;
        hold_line(1'b0, BIT_CLK);
        for (int i = 0; i < nb; i++) hold_line(d[i], BIT_CLK);
        if (cfg_par_en) begin
            p = 1'b0;
            for (int i = 0; i < nb; i++) p = p ^ d[i];
            p = p ^ cfg_par_odd ^ flip_par;
            hold_line(p, BIT_CLK);
        end
        hold_line(stop_v, BIT_CLK);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic check_char(input string req, input logic [7:0] d, input bit pe,
                              input bit fe, input bit ov);
        logic [7:0] exp_d;
        exp_d = cfg_len8 ? d : {1'b0, d[6:0]};
        check({req, " full"}, int'(rx_full), 1);
        check({req, " data"}, int'(rx_data), int'(exp_d));
        check({req, " perr R4"}, int'(rx_perr), int'(pe));
        check({req, " ferr R5"}, int'(rx_ferr), int'(fe));
        check({req, " ovr R10"}, int'(rx_ovr), int'(ov));
        check({req, " irq R8"}, int'(rx_irq), int'(!mask_rx));
    endtask

    task automatic run_char(input string req, input logic [7:0] d);
        send_frame(d, 1'b0, 1'b1);
        check_char(req, d, 1'b0, 1'b0, 1'b0);
        check("R9 single char", int'(rx_ren_n), 0);
        do_read();
        check("R7 read clears", int'(rx_full), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset full", int'(rx_full), 0);
        check("R8 reset irq", int'(rx_irq), 0);
        check("R9 reset ren", int'(rx_ren_n), 0);

        // R3: all 8-bit values, no parity
        cfg_len8 = 1'b1; cfg_par_en = 1'b0;
        for (int v = 0; v < 256; v++) run_char("R3 8bit", 8'(v));

        // R3 R4: 7-bit even parity, bit 7 driven in data but not sent
        cfg_len8 = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        for (int v = 1; v < 256; v += 4) run_char("R3 7bit even", 8'(v));

        // R4: 8-bit odd parity
        cfg_len8 = 1'b1; cfg_par_odd = 1'b1;
        for (int v = 0; v < 256; v += 4) run_char("R4 8bit odd", 8'(v));

        // R4 R6: parity error is delivered, next char unaffected
        cfg_par_odd = 1'b0;
        send_frame(8'hA7, 1'b1, 1'b1);
        check_char("R4 bad parity", 8'hA7, 1'b1, 1'b0, 1'b0);
        do_read();
        run_char("R6 after perr", 8'h3C);

        // R5: framing error
        cfg_par_en = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0);
        rxd = 1'b1;
        check_char("R5 ferr", 8'h55, 1'b0, 1'b1, 1'b0);
        do_read();
        run_char("R6 after ferr", 8'hC3);

        // R2: short glitch is rejected
        hold_line(1'b0, 6);
        hold_line(1'b1, 3 * BIT_CLK);
        check("R2 glitch ignored", int'(rx_full), 0);
        run_char("R2 after glitch", 8'h81);

        // R1: break gives one char, no repeat while held low
        send_frame(8'h00, 1'b0, 1'b0);
        check_char("R1 break", 8'h00, 1'b0, 1'b1, 1'b0);
        do_read();
        hold_line(1'b0, 30 * BIT_CLK);
        check("R1 no restart in break", int'(rx_full), 0);
        hold_line(1'b1, 2 * BIT_CLK);
        run_char("R1 after break", 8'h6E);

        // R8: masked interrupt
        mask_rx = 1'b1;
        send_frame(8'h12, 1'b0, 1'b1);
        check_char("R8 masked", 8'h12, 1'b0, 1'b0, 1'b0);
        do_read();
        mask_rx = 1'b0;

        // R6 R7 R9 R10: double buffering
        send_frame(8'h11, 1'b0, 1'b1);
        check("R9 one stage", int'(rx_ren_n), 0);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R6 first kept", int'(rx_data), 8'h11);
        check("R9 both full", int'(rx_ren_n), 1);
        send_frame(8'h33, 1'b0, 1'b1);
        check("R10 third lost", int'(rx_data), 8'h11);
        check("R10 still full", int'(rx_ren_n), 1);
        do_read();
        check("R7 gap after read", int'(rx_full), 0);
        @(negedge clk);
        check_char("R7 promoted", 8'h22, 1'b0, 1'b0, 1'b1);
        check("R9 one left", int'(rx_ren_n), 0);
        do_read();
        check("R7 empty", int'(rx_full), 0);
        repeat (BIT_CLK) @(negedge clk);
        check("R10 nothing started", int'(rx_full), 0);
        run_char("R10 next clean", 8'h44);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule